// File: doc/BRIEF.md
# NOR Flash Operation Sequencer

This block sits on the host side of a parallel NOR flash. It takes one high-level request at a time and turns it into the bus cycles the device expects. The requests are word program, block erase, whole-chip erase, identifier read and block unlock. For each request it writes the command words in order and polls the device status until the ready bit appears. It then sorts the error bits into one of a small set of result codes and leaves the device in array-read mode with a final 0xFF write.

The flash bus is a simple strobe/ready port. One strobe, either write or read, is raised together with the address and write data. All three are held until `fl_ready` is seen high at a rising edge, and that edge completes the cycle. Read data is taken on that same edge. Erase is a fixed chain of steps: reset, a lock-status check through the identifier command, an unlock only if the block is locked, a status clear, the two-word erase command, polling, and the error decode. The device has no native chip-erase command, so chip erase repeats this chain over every block.

Top module: `flash_op_seq`

## Requirements
- R1: Opcode 0 (program) at address A with word D issues writes 0xFF@A, 0x10@A, D@A. It then repeats the pair (write 0x70@A, read @A) until a read returns bit 7 set. On success it writes 0x50@A and 0xFF@A and completes with error code 0.
- R2: In a program, a ready status with bit 3, bit 4 or bit 1 set completes with error code 1 after a single 0xFF@A write. Bits 0, 2 and 5 of the status have no effect on a program result.
- R3: Opcode 1 (block erase) works on base B, which is A with its low BLK_W bits cleared. The sequence is 0xFF@B, 0x90@(B+2), read @(B+2), 0xFF@B. If bit 0 of that read is set, it writes 0x60@B and 0xD0@B. It then writes 0x50@B, 0x20@B and 0xD0@B, polls as in R1 at B, and ends with 0xFF@B. The result is error code 0 when no fault bit is set.
- R4: In an erase, a ready status with bit 1, 3, 4 or 5 set completes with error code 2 after 0xFF@B.
- R5: Opcode 2 (chip erase) runs the R3 sequence on blocks 0 to NBLK-1 in index order, where block k has base k·2^BLK_W. It stops after the first block that fails and reports that block's error code.
- R6: Opcode 3 (identifier read) at A issues 0xFF@A, 0x90@A, read @A, 0xFF@A. The word read is presented on `req_rdata` with error code 0.
- R7: Opcode 4 (unlock) at A issues 0xFF@A, 0x60@A, 0xD0@A, 0xFF@A and completes with error code 0.
- R8: If POLL_LIMIT status reads in a row return bit 7 clear, the operation ends with error code 3 after a 0xFF write at the operation address.
- R9: The write and read strobes are never high together. While a strobe is high and `fl_ready` is low, the strobe, address and write data stay unchanged.
- R10: `req_done` is a one-cycle pulse in the cycle after the final 0xFF write is accepted. `req_err` and `req_rdata` are valid with it. `req_start` has no effect while an operation runs, and opcodes 5 to 7 are ignored: they cause no bus cycle and no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_op | input | 3 | Operation code (0 program, 1 block erase, 2 chip erase, 3 identifier, 4 unlock) |
| req_addr | input | AW | Word address of the operation |
| req_wdata | input | DW | Word to program |
| req_start | input | 1 | Start pulse, sampled while idle |
| req_done | output | 1 | One-cycle completion pulse |
| req_err | output | 2 | Result: 0 ok, 1 write fail, 2 erase fail, 3 timeout |
| req_rdata | output | DW | Last word read through the identifier command |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | DW | Flash write data |
| fl_rdata | input | DW | Flash read data |
| fl_we | output | 1 | Write strobe |
| fl_re | output | 1 | Read strobe |
| fl_ready | input | 1 | Completes the current strobe at a rising edge |

## Verification
A start pulse is taken at the first rising edge while idle, and the first strobe shows up one cycle later. Every bus cycle lasts until an edge with `fl_ready` high, so the bench does not count fixed latencies. It logs each accepted cycle at the rising edge and compares the whole log to a sequence it builds itself from the request, the lock pattern, the busy count and the injected status bits. The done pulse comes one cycle after the final 0xFF is accepted, and `req_err` and `req_rdata` are read in that same cycle. The bench samples all of them on falling edges. The one-cycle gap after the 0xFF write is also held by a clocked property.

// File: rtl/flseq_pkg.sv
package flseq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RST, ST_IDCMD, ST_IDRD, ST_IDRST, ST_ULSET, ST_ULCONF,
    ST_CLR, ST_CMD1, ST_CMD2, ST_PCMD, ST_PRD, ST_CLR2, ST_FIN, ST_DONE
  } flseq_st_e;

  localparam logic [2:0] OP_PROG   = 3'd0;
  localparam logic [2:0] OP_BERASE = 3'd1;
  localparam logic [2:0] OP_CERASE = 3'd2;
  localparam logic [2:0] OP_IDENT  = 3'd3;
  localparam logic [2:0] OP_UNLOCK = 3'd4;

  localparam logic [1:0] ERR_OK      = 2'd0;
  localparam logic [1:0] ERR_WRITE   = 2'd1;
  localparam logic [1:0] ERR_ERASE   = 2'd2;
  localparam logic [1:0] ERR_TIMEOUT = 2'd3;

  localparam logic [7:0] C_ARRAY   = 8'hFF;
  localparam logic [7:0] C_IDENT   = 8'h90;
  localparam logic [7:0] C_STATUS  = 8'h70;
  localparam logic [7:0] C_CLRSTAT = 8'h50;
  localparam logic [7:0] C_LOCKSET = 8'h60;
  localparam logic [7:0] C_CONFIRM = 8'hD0;
  localparam logic [7:0] C_PROGRAM = 8'h10;
  localparam logic [7:0] C_ERASE   = 8'h20;
endpackage

// File: rtl/flseq_cycle.sv
// Maps the sequencer state to the bus cycle it drives (DW must be at least 8).
module flseq_cycle
  import flseq_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  flseq_st_e        st,
  input  logic             is_prog,
  input  logic [AW-1:0]    op_addr,
  input  logic [AW-1:0]    id_addr,
  input  logic [DW-1:0]    prog_word,
  output logic             we,
  output logic             re,
  output logic [AW-1:0]    addr,
  output logic [DW-1:0]    wdata
);
  logic [7:0] cmd;
  logic       use_word;

  always_comb begin
    we       = 1'b1;
    re       = 1'b0;
    cmd      = C_ARRAY;
    use_word = 1'b0;
    addr     = op_addr;
    case (st)
      ST_RST, ST_IDRST, ST_FIN: cmd = C_ARRAY;
      ST_IDCMD:  begin cmd = C_IDENT; addr = id_addr; end
      ST_IDRD:   begin we = 1'b0; re = 1'b1; addr = id_addr; end
      ST_ULSET:  cmd = C_LOCKSET;
      ST_ULCONF: cmd = C_CONFIRM;
      ST_CLR, ST_CLR2: cmd = C_CLRSTAT;
      ST_CMD1:   cmd = is_prog ? C_PROGRAM : C_ERASE;
      ST_CMD2:   begin cmd = C_CONFIRM; use_word = is_prog; end
      ST_PCMD:   cmd = C_STATUS;
      ST_PRD:    begin we = 1'b0; re = 1'b1; end
      default:   we = 1'b0;
    endcase
    wdata = use_word ? prog_word : {{(DW-8){1'b0}}, cmd};
  end
endmodule

// File: rtl/flseq_status.sv
// Decodes a polled status word into ready and fault.
module flseq_status (
  input  logic ready_bit,
  input  logic vpp_bit,
  input  logic prog_bit,
  input  logic erase_bit,
  input  logic lock_bit,
  input  logic is_erase,
  output logic ready,
  output logic fault
);
  assign ready = ready_bit;
  assign fault = vpp_bit | prog_bit | lock_bit | (is_erase & erase_bit);
endmodule

// File: rtl/flseq_polltimer.sv
// Counts not-ready status reads; flags the read that uses up the budget.
module flseq_polltimer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic miss,
  output logic last
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (miss) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clr || miss)  cnt_q <= cnt_d;
  end

  assign last = miss && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
  import flseq_pkg::*;
#(
  parameter int DW         = 16,
  parameter int NBLK       = 4,
  parameter int BLK_W      = 4,
  parameter int POLL_LIMIT = 64,
  localparam int IW        = $clog2(NBLK),
  localparam int AW        = IW + BLK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_start,
  output logic          req_done,
  output logic [1:0]    req_err,
  output logic [DW-1:0] req_rdata,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  input  logic [DW-1:0] fl_rdata,
  output logic          fl_we,
  output logic          fl_re,
  input  logic          fl_ready
);
  // reset: asserted at once, released after two clock edges
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  flseq_st_e     st_q, st_d;
  logic [2:0]    op_q;
  logic [AW-1:0] addr_q, addr_ld;
  logic [DW-1:0] wdata_q, rdata_q;
  logic [IW-1:0] blk_q;
  logic [1:0]    err_q, err_d;
  logic          ld_req, ld_err, ld_rdata, adv_blk;
  logic          acc, is_prog, is_erase, st_ready, st_fault, poll_last;
  logic          op_ok, req_erase;
  logic [AW-1:0] id_addr;

  assign acc       = fl_ready && (fl_we || fl_re);
  assign is_prog   = (op_q == OP_PROG);
  assign is_erase  = (op_q == OP_BERASE) || (op_q == OP_CERASE);
  assign op_ok     = (req_op <= OP_UNLOCK);
  assign req_erase = (req_op == OP_BERASE);
  assign id_addr   = is_erase ? {addr_q[AW-1:2], 2'b10} : addr_q;
  assign addr_ld   = (req_op == OP_CERASE) ? '0 :
                     req_erase ? {req_addr[AW-1:BLK_W], {BLK_W{1'b0}}} : req_addr;

  flseq_cycle #(.AW(AW), .DW(DW)) u_cycle (
    .st(st_q), .is_prog(is_prog), .op_addr(addr_q), .id_addr(id_addr),
    .prog_word(wdata_q), .we(fl_we), .re(fl_re), .addr(fl_addr), .wdata(fl_wdata)
  );

  flseq_status u_status (
    .ready_bit(fl_rdata[7]), .vpp_bit(fl_rdata[3]), .prog_bit(fl_rdata[4]),
    .erase_bit(fl_rdata[5]), .lock_bit(fl_rdata[1]), .is_erase(is_erase),
    .ready(st_ready), .fault(st_fault)
  );

  flseq_polltimer #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst_n(rst_i_n), .clr(st_q == ST_CMD2),
    .miss((st_q == ST_PRD) && acc && !st_ready), .last(poll_last)
  );

  // next state
  always_comb begin
    st_d     = st_q;
    err_d    = err_q;
    ld_req   = 1'b0;
    ld_err   = 1'b0;
    ld_rdata = 1'b0;
    adv_blk  = 1'b0;
    case (st_q)
      ST_IDLE: if (req_start && op_ok) begin ld_req = 1'b1; st_d = ST_RST; end
      ST_RST: if (acc)
        st_d = (op_q == OP_UNLOCK) ? ST_ULSET : (is_prog ? ST_CMD1 : ST_IDCMD);
      ST_IDCMD: if (acc) st_d = ST_IDRD;
      ST_IDRD: if (acc) begin
        ld_rdata = 1'b1;
        st_d = (op_q == OP_IDENT) ? ST_FIN : ST_IDRST;
      end
      ST_IDRST:  if (acc) st_d = rdata_q[0] ? ST_ULSET : ST_CLR;
      ST_ULSET:  if (acc) st_d = ST_ULCONF;
      ST_ULCONF: if (acc) st_d = (op_q == OP_UNLOCK) ? ST_FIN : ST_CLR;
      ST_CLR:    if (acc) st_d = ST_CMD1;
      ST_CMD1:   if (acc) st_d = ST_CMD2;
      ST_CMD2:   if (acc) st_d = ST_PCMD;
      ST_PCMD:   if (acc) st_d = ST_PRD;
      ST_PRD: if (acc) begin
        if (!st_ready) begin
          if (poll_last) begin err_d = ERR_TIMEOUT; ld_err = 1'b1; st_d = ST_FIN; end
          else st_d = ST_PCMD;
        end else if (st_fault) begin
          err_d  = is_prog ? ERR_WRITE : ERR_ERASE;
          ld_err = 1'b1;
          st_d   = ST_FIN;
        end else begin
          st_d = is_prog ? ST_CLR2 : ST_FIN;
        end
      end
      ST_CLR2: if (acc) st_d = ST_FIN;
      ST_FIN: if (acc) begin
        if (op_q == OP_CERASE && err_q == ERR_OK && blk_q != IW'(NBLK - 1)) begin
          adv_blk = 1'b1;
          st_d    = ST_RST;
        end else st_d = ST_DONE;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_PROG;
      addr_q  <= '0;
      wdata_q <= '0;
      blk_q   <= '0;
      err_q   <= ERR_OK;
      rdata_q <= '0;
    end else begin
      st_q <= st_d;
      if (ld_req) begin
        op_q    <= req_op;
        wdata_q <= req_wdata;
        addr_q  <= addr_ld;
        blk_q   <= (req_op == OP_CERASE) ? '0 : req_addr[AW-1:BLK_W];
        err_q   <= ERR_OK;
      end else if (adv_blk) begin
        blk_q  <= blk_q + 1'b1;
        addr_q <= {blk_q + 1'b1, {BLK_W{1'b0}}};
      end
      if (ld_err)   err_q   <= err_d;
      if (ld_rdata) rdata_q <= fl_rdata;
    end
  end

  assign req_done  = (st_q == ST_DONE);
  assign req_err   = err_q;
  assign req_rdata = rdata_q;
endmodule

// File: rtl/flseq_chk.sv
module flseq_chk #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_done,
  input logic [AW-1:0] fl_addr,
  input logic [DW-1:0] fl_wdata,
  input logic          fl_we,
  input logic          fl_re,
  input logic          fl_ready
);
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));

  a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ((fl_we || fl_re) && !fl_ready) |=>
      (fl_we == $past(fl_we)) && (fl_re == $past(fl_re)) &&
      $stable(fl_addr) && $stable(fl_wdata));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);

  a_r10_done_after_array_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> $past(fl_we && fl_ready && (fl_wdata[7:0] == 8'hFF)));

  a_r10_quiet_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> !fl_we && !fl_re);
endmodule

bind flash_op_seq flseq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_done(req_done), .fl_addr(fl_addr),
  .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re), .fl_ready(fl_ready)
);

// File: tb/sim_flash_op_seq.sv
module sim_flash_op_seq;
  localparam int DW = 16, NBLK = 4, BLK_W = 4, PL = 16;
  localparam int AW = 6, BS = 16, LOGN = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, req_rdata, fl_wdata, fl_rdata;
  logic req_start = 1'b0, req_done, fl_we, fl_re, fl_ready = 1'b1;
  logic [1:0] req_err;
  logic [AW-1:0] fl_addr;

  always #10 clk = ~clk;

  flash_op_seq #(.DW(DW), .NBLK(NBLK), .BLK_W(BLK_W), .POLL_LIMIT(PL)) u0 (
    .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_start(req_start), .req_done(req_done),
    .req_err(req_err), .req_rdata(req_rdata), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_rdata(fl_rdata), .fl_we(fl_we), .fl_re(fl_re),
    .fl_ready(fl_ready));

  int checks = 0, fails = 0;
  bit finished = 0;

  // ---------------- flash model (bench-owned behaviour) ----------------
  int cfg_busy = 0, cfg_fail_blk = NBLK;
  logic [7:0] cfg_prog_inj = '0, cfg_fail_bits = '0;
  logic [NBLK-1:0] cfg_lock_init = '0;
  logic cfg_load = 0, log_clr = 0;

  int m_mode = 0, m_busy = 0;          // mode 0 array, 1 identifier, 2 status
  logic [7:0] m_err = '0;
  logic m_data_next = 0, m_pend_erase = 0, m_pend_lock = 0;
  logic [NBLK-1:0] m_lock = '0;

  logic log_we [LOGN];
  logic [AW-1:0] log_addr [LOGN];
  logic [DW-1:0] log_data [LOGN];
  int log_n = 0;

  always @(posedge clk) begin
    if (cfg_load) m_lock <= cfg_lock_init;
    if (log_clr) log_n <= 0;
    else if (rst_n && fl_ready && (fl_we || fl_re)) begin
      if (log_n < LOGN) begin
        log_we[log_n] <= fl_we; log_addr[log_n] <= fl_addr; log_data[log_n] <= fl_wdata;
      end
      log_n <= log_n + 1;
      if (fl_re && m_mode == 2 && m_busy > 0) m_busy <= m_busy - 1;
      if (fl_we) begin
        m_pend_erase <= 0; m_pend_lock <= 0; m_data_next <= 0;
        if (m_data_next) begin
          m_busy <= cfg_busy; m_err <= cfg_prog_inj; m_mode <= 2;
        end else case (fl_wdata[7:0])
          8'hFF: m_mode <= 0;
          8'h90: m_mode <= 1;
          8'h70: m_mode <= 2;
          8'h50: m_err <= '0;
          8'h10: m_data_next <= 1;
          8'h20: m_pend_erase <= 1;
          8'h60: m_pend_lock <= 1;
          8'hD0: if (m_pend_erase) begin
                   m_busy <= cfg_busy; m_mode <= 2;
                   m_err <= (int'(fl_addr[AW-1:BLK_W]) == cfg_fail_blk) ? cfg_fail_bits :
                            (m_lock[fl_addr[AW-1:BLK_W]] ? 8'h02 : 8'h00);
                 end else if (m_pend_lock) m_lock[fl_addr[AW-1:BLK_W]] <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    fl_rdata = 16'hFFFF;
    if (m_mode == 1) begin
      case (fl_addr[1:0])
        2'd0: fl_rdata = 16'h0089;
        2'd1: fl_rdata = 16'h8817;
        2'd2: fl_rdata = {15'd0, m_lock[fl_addr[AW-1:BLK_W]]};
        default: fl_rdata = 16'h0000;
      endcase
    end else if (m_mode == 2) fl_rdata = (m_busy > 0) ? 16'h0000 : {8'h00, 8'h80 | m_err};
  end

  // random ready stalls, R9 bus rule monitor
  bit rdy_random = 0;
  int r9_bad = 0;
  logic pv_we = 0, pv_re = 0, pv_rdy = 1;
  logic [AW-1:0] pv_addr = '0;
  logic [DW-1:0] pv_data = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (fl_we && fl_re) r9_bad++;
      if ((pv_we || pv_re) && !pv_rdy &&
          (fl_we != pv_we || fl_re != pv_re || fl_addr != pv_addr || fl_wdata != pv_data))
        r9_bad++;
    end
    pv_we = fl_we; pv_re = fl_re; pv_addr = fl_addr; pv_data = fl_wdata;
    fl_ready = rdy_random ? (($urandom % 4) != 0) : 1'b1;
    pv_rdy = fl_ready;
  end

  // ---------------- expected sequence ----------------
  logic exp_we [LOGN];
  logic [AW-1:0] exp_addr [LOGN];
  logic [DW-1:0] exp_data [LOGN];
  int exp_n = 0;

  task automatic push(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_we[exp_n] = we; exp_addr[exp_n] = a; exp_data[exp_n] = d; exp_n++;
  endtask

  function automatic bit timed_out();
    return cfg_busy >= PL;
  endfunction

  task automatic exp_poll(input logic [AW-1:0] a);
    int n;
    n = timed_out() ? PL : cfg_busy + 1;
    for (int i = 0; i < n; i++) begin push(1, a, 16'h70); push(0, a, '0); end
  endtask

  task automatic exp_prog(input logic [AW-1:0] a, input logic [DW-1:0] d, output logic [1:0] e);
    push(1, a, 16'hFF); push(1, a, 16'h10); push(1, a, d); exp_poll(a);
    if (timed_out()) e = 2'd3;
    else if ((cfg_prog_inj & 8'h1A) != 0) e = 2'd1;
    else begin e = 2'd0; push(1, a, 16'h50); end
    push(1, a, 16'hFF);
  endtask

  task automatic exp_erase(input int b, output logic [1:0] e);
    logic [AW-1:0] base;
    logic [7:0] bits;
    base = AW'(b * BS);
    bits = (b == cfg_fail_blk) ? cfg_fail_bits : 8'h00;
    push(1, base, 16'hFF); push(1, base | 6'd2, 16'h90); push(0, base | 6'd2, '0);
    push(1, base, 16'hFF);
    if (cfg_lock_init[b]) begin push(1, base, 16'h60); push(1, base, 16'hD0); end
    push(1, base, 16'h50); push(1, base, 16'h20); push(1, base, 16'hD0); exp_poll(base);
    push(1, base, 16'hFF);
    e = timed_out() ? 2'd3 : ((bits & 8'h3A) != 0 ? 2'd2 : 2'd0);
  endtask

  task automatic expect_op(input logic [2:0] op, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, output logic [1:0] e,
                           output logic [DW-1:0] rd);
    logic [1:0] eb;
    exp_n = 0; e = 0; rd = 'x;
    case (op)
      3'd0: exp_prog(a, d, e);
      3'd1: exp_erase(int'(a[AW-1:BLK_W]), e);
      3'd2: for (int b = 0; b < NBLK; b++) begin
              exp_erase(b, eb); e = eb;
              if (eb != 0) break;
            end
      3'd3: begin
              push(1, a, 16'hFF); push(1, a, 16'h90); push(0, a, '0); push(1, a, 16'hFF);
              case (a[1:0])
                2'd0: rd = 16'h0089;
                2'd1: rd = 16'h8817;
                2'd2: rd = {15'd0, cfg_lock_init[a[AW-1:BLK_W]]};
                default: rd = 16'h0000;
              endcase
            end
      default: begin push(1, a, 16'hFF); push(1, a, 16'h60); push(1, a, 16'hD0); push(1, a, 16'hFF); end
    endcase
  endtask

  function automatic string tag_of(input logic [2:0] op, input logic [1:0] e);
    if (e == 2'd3) return "R8";
    case (op)
      3'd0: return (e != 0) ? "R2" : "R1";
      3'd1: return (e != 0) ? "R4" : "R3";
      3'd2: return "R5";
      3'd3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic check_log(input string tag);
    int bad;
    bad = -1;
    if (log_n == exp_n)
      for (int i = 0; i < exp_n; i++)
        if (log_we[i] != exp_we[i] || log_addr[i] != exp_addr[i] ||
            (exp_we[i] && log_data[i] != exp_data[i])) begin bad = i; break; end
    if (log_n != exp_n) check(0, tag, "bus cycle count", log_n, exp_n);
    else if (bad >= 0)
      check(0, tag, $sformatf("bus cycle %0d we/addr/data", bad),
            {log_we[bad], 2'b0, log_addr[bad], log_data[bad]},
            {exp_we[bad], 2'b0, exp_addr[bad], exp_data[bad]});
    else check(1, tag, "bus sequence", 0, 0);
  endtask

  // start op; optionally send a second start while busy
  task automatic run_op(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit reload, input bit poke_busy);
    logic [1:0] e_exp;
    logic [DW-1:0] rd_exp;
    bit seen;
    string tag;
    @(negedge clk);
    cfg_load = reload; log_clr = 1;
    @(negedge clk);
    cfg_load = 0; log_clr = 0;
    expect_op(op, a, d, e_exp, rd_exp);
    tag = poke_busy ? "R10" : tag_of(op, e_exp);
    req_op = op; req_addr = a; req_wdata = d; req_start = 1;
    @(negedge clk);
    req_start = 0;
    seen = 0;
    for (int i = 0; i < 6000; i++) begin
      if (poke_busy && i == 3) begin req_op = 3'd4; req_addr = ~a; req_start = 1; end
      if (poke_busy && i == 4) req_start = 0;
      if (req_done) begin seen = 1; break; end
      @(negedge clk);
    end
    check(seen, tag, "done pulse seen", seen, 1);
    check(req_err == e_exp, tag, "error code", req_err, e_exp);
    if (op == 3'd3) check(req_rdata == rd_exp, tag, "identifier word", req_rdata, rd_exp);
    @(negedge clk);
    check(!req_done, "R10", "done is one cycle", req_done, 0);
    check_log(tag);
  endtask

  task automatic cfg(input int busy, input logic [7:0] pinj, input int fblk,
                     input logic [7:0] fbits, input logic [NBLK-1:0] locks);
    cfg_busy = busy; cfg_prog_inj = pinj; cfg_fail_blk = fblk;
    cfg_fail_bits = fbits; cfg_lock_init = locks;
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 190000);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    finish_up();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(!req_done && !fl_we && !fl_re && req_err == 0, "R10", "reset state",
          {req_done, fl_we, fl_re, req_err}, 0);

    // directed corners
    cfg(2, 8'h00, NBLK, 8'h00, 4'b0000); run_op(3'd0, 6'h13, 16'hA5C3, 1, 0);   // R1
    cfg(0, 8'h10, NBLK, 8'h00, 4'b0000); run_op(3'd0, 6'h07, 16'h0070, 1, 0);   // R2 bit4
    cfg(1, 8'h08, NBLK, 8'h00, 4'b0000); run_op(3'd0, 6'h07, 16'h1111, 1, 0);   // R2 bit3
    cfg(1, 8'h02, NBLK, 8'h00, 4'b0000); run_op(3'd0, 6'h21, 16'h2222, 1, 0);   // R2 bit1
    cfg(1, 8'h25, NBLK, 8'h00, 4'b0000); run_op(3'd0, 6'h22, 16'h3333, 1, 0);   // R2 ignored bits -> R1 path
    cfg(3, 8'h00, NBLK, 8'h00, 4'b0100); run_op(3'd1, 6'h25, 16'h0, 1, 0);      // R3 locked
    cfg(0, 8'h00, NBLK, 8'h00, 4'b0000); run_op(3'd1, 6'h3F, 16'h0, 1, 0);      // R3 unlocked
    cfg(2, 8'h00, 1, 8'h20, 4'b0011);    run_op(3'd1, 6'h11, 16'h0, 1, 0);      // R4 bit5
    cfg(2, 8'h00, 0, 8'h08, 4'b0000);    run_op(3'd1, 6'h01, 16'h0, 1, 0);      // R4 bit3
    cfg(1, 8'h00, NBLK, 8'h00, 4'b1010); run_op(3'd2, 6'h00, 16'h0, 1, 0);      // R5 all ok
    cfg(1, 8'h00, 2, 8'h10, 4'b0101);    run_op(3'd2, 6'h00, 16'h0, 1, 0);      // R5 stop at 2
    cfg(0, 8'h00, NBLK, 8'h00, 4'b0100);
    run_op(3'd3, 6'h20, 16'h0, 1, 0);                                           // R6 manufacturer
    run_op(3'd3, 6'h21, 16'h0, 0, 0);                                           // R6 device
    run_op(3'd3, 6'h22, 16'h0, 0, 0);                                           // R6 lock = 1
    run_op(3'd4, 6'h24, 16'h0, 0, 0);                                           // R7 unlock
    cfg_lock_init = 4'b0000;
    run_op(3'd3, 6'h22, 16'h0, 0, 0);                                           // R7 lock now 0
    cfg(40, 8'h00, NBLK, 8'h00, 4'b0000); run_op(3'd0, 6'h05, 16'h5555, 1, 0);  // R8 program
    cfg(40, 8'h00, NBLK, 8'h00, 4'b0001); run_op(3'd2, 6'h00, 16'h0, 1, 0);     // R8 chip erase
    cfg(2, 8'h00, NBLK, 8'h00, 4'b0000); run_op(3'd0, 6'h0A, 16'h9999, 1, 1);   // R10 start while busy

    // R10: unused opcode ignored
    begin
      bit any_done;
      @(negedge clk); log_clr = 1; @(negedge clk); log_clr = 0;
      req_op = 3'd6; req_start = 1; @(negedge clk); req_start = 0;
      any_done = 0;
      for (int i = 0; i < 30; i++) begin if (req_done) any_done = 1; @(negedge clk); end
      check(!any_done && log_n == 0, "R10", "opcode 6 ignored", {any_done, log_n}, 0);
    end

    // constrained random with ready stalls
    rdy_random = 1;
    for (int k = 0; k < 40; k++) begin
      logic [7:0] injs [6];
      logic [7:0] ebits [4];
      injs = '{8'h00, 8'h00, 8'h02, 8'h08, 8'h10, 8'h21};
      ebits = '{8'h20, 8'h10, 8'h08, 8'h02};
      cfg($urandom % 6, injs[$urandom % 6], $urandom % (NBLK + 2),
          ebits[$urandom % 4], NBLK'($urandom));
      run_op(3'($urandom % 5), AW'($urandom), DW'($urandom), 1, 0);
    end
    rdy_random = 0;

    check(r9_bad == 0, "R9", "strobe exclusivity and hold", r9_bad, 0);
    finish_up();
  end
endmodule